// File: doc/BRIEF.md
# Interrupt Aggregation and Mode Control Register Unit

This unit collects interrupt requests from six peripheral engines of a system coprocessor (signal processor, serial link, audio, video, parallel port and display processor) and folds them into a single registered request line for the host processor. Each engine raises or drops its own pending bit through one-cycle pulses. Software selects which pending bits may reach the host through a six-bit enable mask.

A second register holds a 7-bit initialisation length and three mode flags: init mode, bus test and memory-register mode. Software never writes the mask or the flags as plain values. Every bit has a dedicated clear command bit and a set command bit in the write word. One mode command bit also drops the display processor's pending request. Write data is qualified by a per-bit lane mask before any command bit is decoded.

Register offsets on the word-address bus are as follows. Offset 0 is the mode register. Offset 1 is the pending register, which is read-only. Offset 2 is the enable mask. Offset 3 reads as zero.

Top module: `irq_mode_unit`

## Requirements
- R1: While reset is asserted, and until new events arrive after reset, the pending, mask, length and flag registers and `irq_out` are all zero.
- R2: Mask bit n corresponds to a source in this order, starting at bit 0: signal processor, serial, audio, video, parallel, display processor. A write to offset 2 clears mask bit n when effective write bit 2n is set, and sets mask bit n when effective write bit 2n+1 is set, for n = 0..5. A mask read returns the six mask bits in rdata[5:0].
- R3: When the clear and set commands for the same mask bit or mode flag arrive in one write, the bit ends up set.
- R4: Every write to offset 0 loads effective write bits 6:0 into the length field. A mode read returns the length field in rdata[6:0].
- R5: In a write to offset 0, effective bits 7/8 clear/set the init flag, bits 9/10 clear/set the bus-test flag, and bits 12/13 clear/set the memory-register flag. A mode read returns these flags at rdata bits 7, 8 and 9.
- R6: A write to offset 0 with effective bit 11 set clears pending bit 5 (display processor).
- R7: The effective write word is bus_wdata AND bus_wmask. Bits with a zero mask bit have no effect.
- R8: A raise pulse on source i sets pending bit i. A clear pulse clears it. When a raise pulse coincides with a clear pulse or with the R6 clear, the raise wins. A pending read returns the pending bits in rdata[5:0].
- R9: `irq_out` is registered. It is high on the cycle after one in which pending AND mask is non-zero, and low otherwise.
- R10: Writes to offset 1 or offset 3 change no state. Reads of offset 3 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 2 | Word offset of the register |
| bus_wdata | input | 32 | Write data / command word |
| bus_wmask | input | 32 | Per-bit lane mask applied to write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| src_raise | input | 6 | Per-source pending set pulses |
| src_clear | input | 6 | Per-source pending clear pulses |
| irq_out | output | 1 | Registered combined interrupt request |

## Verification
The bench targets the cases where a clear and a set command collide. A design that applies the commands in the wrong order leaves a bit cleared that should read back set. It also collides a raise with both a clear pulse and the mode-register clear of the display processor bit. A design with the wrong priority silently drops a live request. The bench checks lane masking with command bits hidden under zero mask lanes, so a design that decodes raw data would flip mask or flag bits. It also checks the one-cycle lag of the request line, which catches a combinational output or one delayed by an extra register.

// File: rtl/irq_mode_pkg.sv
package irq_mode_pkg;
  localparam int NSRC      = 6;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 2;
  localparam int LEN_W     = 7;
  localparam int NFLAG     = 3;
  localparam int DP_SRC    = 5;
  localparam int DP_CLR_BIT = 11;

  typedef enum logic [ADDR_W-1:0] {
    OFS_MODE = 2'd0,
    OFS_PEND = 2'd1,
    OFS_MASK = 2'd2,
    OFS_NONE = 2'd3
  } reg_ofs_e;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/irq_clrset_bank.sv
module irq_clrset_bank #(
  parameter int NBITS = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_en,
  input  logic [2*NBITS-1:0] cmd,
  output logic [NBITS-1:0]   q
);
  logic [NBITS-1:0] q_d;
  logic [NBITS-1:0] q_r;

  for (genvar i = 0; i < NBITS; i++) begin : g_bit
    always_comb begin
      q_d[i] = q_r[i];
      if (cmd[2*i])   q_d[i] = 1'b0;
      if (cmd[2*i+1]) q_d[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_r <= '0;
    else if (cmd_en) q_r <= q_d;
  end

  assign q = q_r;
endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
  parameter int NSRC = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] raise,
  input  logic [NSRC-1:0] hw_clear,
  input  logic [NSRC-1:0] sw_clear,
  output logic [NSRC-1:0] pend
);
  logic [NSRC-1:0] pend_d;
  logic [NSRC-1:0] pend_r;
  logic            upd_en;

  assign upd_en = |{raise, hw_clear, sw_clear};

  always_comb begin
    pend_d = (pend_r & ~(hw_clear | sw_clear)) | raise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend_r <= '0;
    else if (upd_en) pend_r <= pend_d;
  end

  assign pend = pend_r;
endmodule

// File: rtl/irq_mode_unit.sv
module irq_mode_unit
  import irq_mode_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_wmask,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NSRC-1:0]   src_raise,
  input  logic [NSRC-1:0]   src_clear,
  output logic              irq_out
);
  localparam int MODE_RD_W = LEN_W + NFLAG;

  logic                 rst_sync_n;
  logic [DATA_W-1:0]    wr_eff;
  logic                 mode_wr;
  logic                 mask_wr;
  logic [NSRC-1:0]      mask_q;
  logic [NSRC-1:0]      pend_q;
  logic [NSRC-1:0]      sw_clr;
  logic [2*NFLAG-1:0]   flag_cmd;
  logic [NFLAG-1:0]     flag_q;
  logic [LEN_W-1:0]     len_q;
  logic [LEN_W-1:0]     len_d;
  logic                 irq_d;
  logic                 irq_q;

  irq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // Command decode on masked write data
  assign wr_eff  = bus_wdata & bus_wmask;
  assign mode_wr = bus_wr && (bus_addr == OFS_MODE);
  assign mask_wr = bus_wr && (bus_addr == OFS_MASK);

  // Mode flag command pairs: init (7/8), bus test (9/10), mem-reg (12/13)
  assign flag_cmd = {wr_eff[13], wr_eff[12], wr_eff[10], wr_eff[9],
                     wr_eff[8],  wr_eff[7]};

  always_comb begin
    sw_clr = '0;
    sw_clr[DP_SRC] = mode_wr && wr_eff[DP_CLR_BIT];
  end

  irq_clrset_bank #(.NBITS(NSRC)) u_mask (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .cmd_en (mask_wr),
    .cmd    (wr_eff[2*NSRC-1:0]),
    .q      (mask_q)
  );

  irq_clrset_bank #(.NBITS(NFLAG)) u_flags (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .cmd_en (mode_wr),
    .cmd    (flag_cmd),
    .q      (flag_q)
  );

  irq_pend_reg #(.NSRC(NSRC)) u_pend (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .raise    (src_raise),
    .hw_clear (src_clear),
    .sw_clear (sw_clr),
    .pend     (pend_q)
  );

  // Init length field
  always_comb begin
    len_d = len_q;
    if (mode_wr) len_d = wr_eff[LEN_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) len_q <= '0;
    else             len_q <= len_d;
  end

  // Combined request, registered
  assign irq_d = |(pend_q & mask_q);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) irq_q <= 1'b0;
    else             irq_q <= irq_d;
  end

  assign irq_out = irq_q;

  // Read mux
  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      OFS_MODE: bus_rdata[MODE_RD_W-1:0] = {flag_q, len_q};
      OFS_PEND: bus_rdata[NSRC-1:0]      = pend_q;
      OFS_MASK: bus_rdata[NSRC-1:0]      = mask_q;
      default:  bus_rdata                = '0;
    endcase
  end
endmodule

// File: rtl/irq_mode_unit_chk.sv
module irq_mode_unit_chk
  import irq_mode_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] wmask,
  input logic [NSRC-1:0]   raise,
  input logic [NSRC-1:0]   clr,
  input logic [NSRC-1:0]   pend,
  input logic [NSRC-1:0]   mask,
  input logic [LEN_W-1:0]  len,
  input logic              irq
);
  logic [DATA_W-1:0] eff;
  logic [NSRC-1:0]   both_cmd;
  logic [NSRC-1:0]   set_cmd;

  assign eff = wdata & wmask;
  for (genvar n = 0; n < NSRC; n++) begin : g_pair
    assign both_cmd[n] = eff[2*n] & eff[2*n+1];
    assign set_cmd[n]  = eff[2*n+1];
  end

  // R9: request follows pending AND mask one cycle later
  assert_irq_lag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|(pend & mask))));

  // R8: a raise pulse always lands, whatever clears coincide
  assert_raise_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (raise != '0) |=> ((pend & $past(raise)) == $past(raise)));

  // R3: clear+set on the same mask bit leaves it set
  assert_both_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == OFS_MASK && both_cmd != '0) |=> ((mask & $past(both_cmd)) == $past(both_cmd)));

  // R2: set command bits reach the mask
  assert_mask_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == OFS_MASK) |=> ((mask & $past(set_cmd)) == $past(set_cmd)));

  // R4: length field takes masked write bits 6:0
  assert_len_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == OFS_MODE) |=> (len == $past(eff[LEN_W-1:0])));

  // R6: mode clear of the display processor bit without a raise
  assert_dp_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == OFS_MODE && eff[DP_CLR_BIT] && !raise[DP_SRC]) |=> !pend[DP_SRC]);

  // R10: writes to the pending offset leave the mask untouched
  assert_pend_wr_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == OFS_PEND) |=> $stable(mask));
endmodule

bind irq_mode_unit irq_mode_unit_chk u_chk (
  .clk   (clk),
  .rst_n (rst_sync_n),
  .wr    (bus_wr),
  .addr  (bus_addr),
  .wdata (bus_wdata),
  .wmask (bus_wmask),
  .raise (src_raise),
  .clr   (src_clear),
  .pend  (pend_q),
  .mask  (mask_q),
  .len   (len_q),
  .irq   (irq_out)
);

// File: tb/sim_irq_mode_unit.sv
module sim_irq_mode_unit;
  typedef struct packed {
    logic [3:0]  req;
    logic        wr;
    logic [1:0]  addr;
    logic [31:0] wd;
    logic [31:0] wm;
    logic [5:0]  rs;
    logic [5:0]  cl;
    logic [1:0]  ra;
    logic [31:0] exp;
    logic        eirq;
  } vec_t;

  localparam logic [31:0] ALL = 32'hFFFF_FFFF;
  localparam int NV = 21;
  // offsets: 0 mode, 1 pending, 2 mask, 3 unused
  localparam vec_t VEC [NV] = '{
    '{4'd2,  1'b1, 2'd2, 32'h0000_0002, ALL, 6'h00, 6'h00, 2'd2, 32'h01,  1'b0}, // R2 set SP
    '{4'd2,  1'b1, 2'd2, 32'h0000_0AA8, ALL, 6'h00, 6'h00, 2'd2, 32'h3F,  1'b0}, // R2 set rest
    '{4'd2,  1'b1, 2'd2, 32'h0000_0004, ALL, 6'h00, 6'h00, 2'd2, 32'h3D,  1'b0}, // R2 clear serial
    '{4'd8,  1'b0, 2'd0, 32'h0,         ALL, 6'h02, 6'h00, 2'd1, 32'h02,  1'b0}, // R8 raise serial
    '{4'd9,  1'b0, 2'd0, 32'h0,         ALL, 6'h01, 6'h00, 2'd1, 32'h03,  1'b1}, // R9 SP reaches irq
    '{4'd8,  1'b0, 2'd0, 32'h0,         ALL, 6'h00, 6'h01, 2'd1, 32'h02,  1'b0}, // R8 clear SP
    '{4'd3,  1'b1, 2'd2, 32'h0000_000C, ALL, 6'h00, 6'h00, 2'd2, 32'h3F,  1'b1}, // R3 clr+set serial
    '{4'd5,  1'b1, 2'd0, 32'h0000_2555, ALL, 6'h00, 6'h00, 2'd0, 32'h3D5, 1'b1}, // R5 set flags, R4
    '{4'd5,  1'b1, 2'd0, 32'h0000_0292, ALL, 6'h00, 6'h00, 2'd0, 32'h212, 1'b1}, // R5 clear two flags
    '{4'd3,  1'b1, 2'd0, 32'h0000_3001, ALL, 6'h00, 6'h00, 2'd0, 32'h201, 1'b1}, // R3 flag clr+set
    '{4'd7,  1'b1, 2'd2, 32'h0000_0F00, 32'h0000_00FF, 6'h00, 6'h00, 2'd2, 32'h3F, 1'b1}, // R7 hidden clear
    '{4'd7,  1'b1, 2'd0, 32'hFFFF_FF7F, 32'h0000_00FF, 6'h00, 6'h00, 2'd0, 32'h27F, 1'b1}, // R7 partial lanes
    '{4'd8,  1'b0, 2'd0, 32'h0,         ALL, 6'h20, 6'h00, 2'd1, 32'h22,  1'b1}, // R8 raise DP
    '{4'd6,  1'b1, 2'd0, 32'h0000_0800, ALL, 6'h00, 6'h00, 2'd1, 32'h02,  1'b1}, // R6 clear DP
    '{4'd4,  1'b0, 2'd0, 32'h0,         ALL, 6'h00, 6'h00, 2'd0, 32'h200, 1'b1}, // R4 length reloaded
    '{4'd10, 1'b1, 2'd1, 32'h0000_003F, ALL, 6'h00, 6'h00, 2'd1, 32'h02,  1'b1}, // R10 pend write ignored
    '{4'd10, 1'b1, 2'd3, 32'hFFFF_FFFF, ALL, 6'h00, 6'h00, 2'd3, 32'h0,   1'b1}, // R10 offset 3
    '{4'd8,  1'b0, 2'd0, 32'h0,         ALL, 6'h20, 6'h20, 2'd1, 32'h22,  1'b1}, // R8 raise beats clear
    '{4'd6,  1'b1, 2'd0, 32'h0000_0800, ALL, 6'h20, 6'h00, 2'd1, 32'h22,  1'b1}, // R6 raise beats mode clear
    '{4'd9,  1'b0, 2'd0, 32'h0,         ALL, 6'h00, 6'h22, 2'd1, 32'h00,  1'b0}, // R9 irq drops
    '{4'd2,  1'b1, 2'd2, 32'h0000_0555, ALL, 6'h00, 6'h00, 2'd2, 32'h00,  1'b0}  // R2 clear all
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_wmask;
  logic [31:0] bus_rdata;
  logic [5:0]  src_raise;
  logic [5:0]  src_clear;
  logic        irq_out;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  irq_mode_unit u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wmask (bus_wmask),
    .bus_rdata (bus_rdata),
    .src_raise (src_raise),
    .src_clear (src_clear),
    .irq_out   (irq_out)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input logic [1:0] ra);
    bus_wr = 1'b0; bus_addr = ra; bus_wdata = '0; bus_wmask = '0;
    src_raise = '0; src_clear = '0;
  endtask

  task automatic read_at(input logic [1:0] ra, output logic [31:0] d);
    @(negedge clk); idle(ra);
    #1 d = bus_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk); idle(2'd0); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    logic [31:0] d;
    idle(2'd0);
    rst_n = 1'b0;
    do_reset();

    // R1: reset state
    read_at(2'd0, d); check("R1 mode", d, 32'h0);
    read_at(2'd1, d); check("R1 pend", d, 32'h0);
    read_at(2'd2, d); check("R1 mask", d, 32'h0);
    check("R1 irq", {31'b0, irq_out}, 32'h0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      bus_wr = VEC[i].wr; bus_addr = VEC[i].addr;
      bus_wdata = VEC[i].wd; bus_wmask = VEC[i].wm;
      src_raise = VEC[i].rs; src_clear = VEC[i].cl;
      @(negedge clk); idle(VEC[i].ra);
      @(negedge clk);
      #1;
      n_chk = n_chk + 1;
      if (bus_rdata !== VEC[i].exp || irq_out !== VEC[i].eirq) begin
        n_fail = n_fail + 1;
        $display("FAIL R%0d vec %0d rdata=%h irq=%b expected rdata=%h irq=%b",
                 VEC[i].req, i, bus_rdata, irq_out, VEC[i].exp, VEC[i].eirq);
      end
    end

    // R9: exact lag of the request line
    @(negedge clk); idle(2'd2);
    bus_wr = 1'b1; bus_wdata = 32'h0000_0800; bus_wmask = ALL;   // enable DP
    @(negedge clk); idle(2'd1); src_raise = 6'h20;              // raise DP
    @(negedge clk); idle(2'd1);                                 // pend updated this edge
    #1 check("R9 irq still low one cycle after raise", {31'b0, irq_out}, 32'h0);
    @(negedge clk);
    #1 check("R9 irq high two edges after raise", {31'b0, irq_out}, 32'h1);

    // R1: reset clears populated state
    @(negedge clk); idle(2'd0);
    bus_wr = 1'b1; bus_wdata = 32'h0000_2555; bus_wmask = ALL;
    @(negedge clk); idle(2'd0);
    do_reset();
    read_at(2'd0, d); check("R1 mode after reset", d, 32'h0);
    read_at(2'd1, d); check("R1 pend after reset", d, 32'h0);
    read_at(2'd2, d); check("R1 mask after reset", d, 32'h0);
    check("R1 irq after reset", {31'b0, irq_out}, 32'h0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule